// File: doc/BRIEF.md
# Serial Save-Memory Type Detector

This block sits on the host side of a serial save-memory port and works out what kind of device is attached. It drives a byte-level handshake towards an SPI master, which handles the bit shifting. It runs a fixed two-command probe. The first transaction reads the device status register. The second asks for a three-byte identification code. The block keeps the response bytes and sorts the device into one of five classes. For each class it also reports the number of address bits the device expects.

A single `start_i` pulse launches a probe. While the probe is running, `busy_o` is high, and any further `start_i` pulses are ignored. The block sends one byte per handshake. For each byte, `keep_sel_o` tells the SPI master whether to keep chip select asserted afterwards. Chip select stays asserted for every byte inside a command and is released at the end of each command. When the last identification byte has been accepted, `done_o` pulses for one cycle, and `kind_o` and `addr_bits_o` carry the result.

Top module: `savemem_probe`

## Requirements
- R1: After reset, `req_o`, `busy_o` and `done_o` are all low.
- R2: The first transaction has two bytes: the status-read command 05h with `keep_sel_o`=1, then a filler FFh with `keep_sel_o`=0. The reply to the filler byte is the status byte.
- R3: The second transaction has four bytes: the ID-read command 9Fh with `keep_sel_o`=1, then three FFh fillers. The fillers carry `keep_sel_o`=1, 1 and 0. Their replies are ID bytes 0, 1 and 2, in that order.
- R4: `done_o` goes high in the cycle after the clock edge that accepts the sixth byte (`req_o` and `ack_i` both high). It stays high for exactly one cycle. It is never high at any other time.
- R5: Status FFh with all three ID bytes FFh gives `kind_o`=0 (no device) and `addr_bits_o`=0.
- R6: Status F0h with all ID bytes FFh gives `kind_o`=1 (EEPROM, 9-bit address) and `addr_bits_o`=9.
- R7: Status 00h with all ID bytes FFh gives `kind_o`=2 (EEPROM or FRAM, 16-bit address) and `addr_bits_o`=16.
- R8: Status 00h with at least one ID byte not equal to FFh gives `kind_o`=3 (FLASH) and `addr_bits_o`=24.
- R9: Every other combination gives `kind_o`=4 (unknown) and `addr_bits_o`=0.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The probe still issues exactly six bytes, and `req_o` stays low after `done_o`.
- R11: Once `req_o` is raised, it stays high with `tx_byte_o` and `keep_sel_o` stable until `ack_i` accepts the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a probe when idle |
| req_o | output | 1 | Byte transfer request to the SPI master |
| tx_byte_o | output | 8 | Byte to shift out |
| keep_sel_o | output | 1 | Keep chip select asserted after this byte |
| ack_i | input | 1 | SPI master has finished the current byte |
| rx_byte_i | input | 8 | Byte shifted in, valid while `ack_i` is high |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle result strobe |
| kind_o | output | 3 | Device class code (0 none, 1 EEPROM 9-bit, 2 EEPROM/FRAM 16-bit, 3 FLASH, 4 unknown) |
| addr_bits_o | output | 5 | Address width of the detected device |

## Verification
Each byte request appears in the cycle after the previous byte was accepted. The bench waits for it at a falling edge and holds `ack_i` for a latency that varies from 0 to 2 cycles. The result is due exactly one cycle after the edge that accepts the sixth byte. The bench therefore samples `done_o`, `kind_o` and `addr_bits_o` at the first falling edge after that acceptance, and checks one falling edge later that the strobe has dropped. A sweep of five status values against five ID patterns covers every class. Two of the probes also inject a stray `start_i` in the middle of the sequence.

// File: rtl/savemem_pkg.sv
package savemem_pkg;
   typedef enum logic [2:0] {
      KIND_NONE    = 3'd0,
      KIND_EE9     = 3'd1,
      KIND_EE16    = 3'd2,
      KIND_FLASH   = 3'd3,
      KIND_UNKNOWN = 3'd4
   } mem_kind_t;

   localparam int BYTE_W    = 8;
   localparam int KIND_W    = 3;
   localparam int ABITS_W   = 5;
endpackage

// File: rtl/savemem_seq.sv
module savemem_seq #(
   parameter int          ID_BYTES = 3,
   parameter logic [7:0]  STAT_CMD = 8'h05,
   parameter logic [7:0]  ID_CMD   = 8'h9F,
   parameter logic [7:0]  FILL     = 8'hFF,
   localparam int         TOTAL    = 3 + ID_BYTES,
   localparam int         IDX_W    = $clog2(TOTAL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic [7:0]       tx_byte_o,
   output logic             keep_sel_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             accept_o,
   output logic [IDX_W-1:0] idx_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
   localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(1);
   localparam logic [IDX_W-1:0] IDC_IDX  = IDX_W'(2);

   logic             busy_q, done_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               idx_q  <= '0;
            end
         end else if (ack_i) begin
            if (idx_q == LAST_IDX) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      if (idx_q == '0)          tx_byte_o = STAT_CMD;
      else if (idx_q == IDC_IDX) tx_byte_o = ID_CMD;
      else                       tx_byte_o = FILL;
      keep_sel_o = !((idx_q == STAT_IDX) || (idx_q == LAST_IDX));
   end

   assign req_o    = busy_q;
   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign accept_o = busy_q && ack_i;
   assign idx_o    = idx_q;
endmodule

// File: rtl/savemem_capture.sv
module savemem_capture #(
   parameter int ID_BYTES = 3,
   parameter int IDX_W    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [7:0]            rx_i,
   output logic [7:0]            status_o,
   output logic [ID_BYTES*8-1:0] id_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)                                  status_o <= '0;
      else if (accept_i && idx_i == IDX_W'(1))     status_o <= rx_i;
   end

   for (genvar k = 0; k < ID_BYTES; k++) begin : g_id
      always_ff @(posedge clk) begin
         if (!rst_n)                                   id_o[k*8 +: 8] <= '0;
         else if (accept_i && idx_i == IDX_W'(3 + k))  id_o[k*8 +: 8] <= rx_i;
      end
   end
endmodule

// File: rtl/savemem_classify.sv
module savemem_classify
   import savemem_pkg::*;
#(
   parameter int         ID_BYTES   = 3,
   parameter logic [7:0] ST_ABSENT  = 8'hFF,
   parameter logic [7:0] ST_SMALL   = 8'hF0,
   parameter logic [7:0] ST_WIDE    = 8'h00,
   parameter int         SMALL_BITS = 9,
   parameter int         WIDE_BITS  = 16,
   parameter int         FLASH_BITS = 24
) (
   input  logic [7:0]            status_i,
   input  logic [ID_BYTES*8-1:0] id_i,
   output mem_kind_t             kind_o,
   output logic [ABITS_W-1:0]    abits_o
);
   logic id_blank;
   assign id_blank = &id_i;

   always_comb begin
      if (id_blank) begin
         if (status_i == ST_ABSENT)     kind_o = KIND_NONE;
         else if (status_i == ST_SMALL) kind_o = KIND_EE9;
         else if (status_i == ST_WIDE)  kind_o = KIND_EE16;
         else                           kind_o = KIND_UNKNOWN;
      end else begin
         if (status_i == ST_WIDE)       kind_o = KIND_FLASH;
         else                           kind_o = KIND_UNKNOWN;
      end
      case (kind_o)
         KIND_EE9:   abits_o = ABITS_W'(SMALL_BITS);
         KIND_EE16:  abits_o = ABITS_W'(WIDE_BITS);
         KIND_FLASH: abits_o = ABITS_W'(FLASH_BITS);
         default:    abits_o = '0;
      endcase
   end
endmodule

// File: rtl/savemem_probe.sv
module savemem_probe
   import savemem_pkg::*;
#(
   parameter int         ID_BYTES   = 3,
   parameter logic [7:0] STAT_CMD   = 8'h05,
   parameter logic [7:0] ID_CMD     = 8'h9F,
   parameter logic [7:0] FILL       = 8'hFF,
   parameter int         FLASH_BITS = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   output logic               req_o,
   output logic [7:0]         tx_byte_o,
   output logic               keep_sel_o,
   input  logic               ack_i,
   input  logic [7:0]         rx_byte_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [KIND_W-1:0]  kind_o,
   output logic [ABITS_W-1:0] addr_bits_o
);
   localparam int TOTAL = 3 + ID_BYTES;
   localparam int IDX_W = $clog2(TOTAL + 1);

   if (ID_BYTES < 1 || ID_BYTES > 8) begin : g_bad_id
      $error("ID_BYTES out of range");
   end
   if (FLASH_BITS >= (1 << ABITS_W)) begin : g_bad_bits
      $error("FLASH_BITS does not fit the address-width output");
   end

   logic                  accept;
   logic [IDX_W-1:0]      idx;
   logic [7:0]            status_q;
   logic [ID_BYTES*8-1:0] id_q;
   mem_kind_t             kind;

   savemem_seq #(
      .ID_BYTES(ID_BYTES), .STAT_CMD(STAT_CMD), .ID_CMD(ID_CMD), .FILL(FILL)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
      .req_o(req_o), .tx_byte_o(tx_byte_o), .keep_sel_o(keep_sel_o),
      .busy_o(busy_o), .done_o(done_o), .accept_o(accept), .idx_o(idx)
   );

   savemem_capture #(.ID_BYTES(ID_BYTES), .IDX_W(IDX_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .idx_i(idx),
      .rx_i(rx_byte_i), .status_o(status_q), .id_o(id_q)
   );

   savemem_classify #(.ID_BYTES(ID_BYTES), .FLASH_BITS(FLASH_BITS)) u_cls (
      .status_i(status_q), .id_i(id_q), .kind_o(kind), .abits_o(addr_bits_o)
   );

   assign kind_o = kind;
endmodule

// File: rtl/savemem_probe_chk.sv
module savemem_probe_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       req_o,
   input logic [7:0] tx_byte_o,
   input logic       keep_sel_o,
   input logic       ack_i,
   input logic       busy_o,
   input logic       done_o,
   input logic [2:0] kind_o,
   input logic [4:0] addr_bits_o
);
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> !req_o && !done_o);

   p_first_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> tx_byte_o == 8'h05 && keep_sel_o);

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(req_o && ack_i) && !req_o);

   p_flash_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && kind_o == 3'd3 |-> addr_bits_o == 5'd24);

   p_unknown_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && kind_o == 3'd4 |-> addr_bits_o == 5'd0);

   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !ack_i |=> busy_o);

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && !ack_i |=> req_o && $stable(tx_byte_o) && $stable(keep_sel_o));
endmodule

bind savemem_probe savemem_probe_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_o(req_o),
   .tx_byte_o(tx_byte_o), .keep_sel_o(keep_sel_o), .ack_i(ack_i),
   .busy_o(busy_o), .done_o(done_o), .kind_o(kind_o), .addr_bits_o(addr_bits_o)
);

// File: tb/tb_savemem_probe.sv
module tb_savemem_probe;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       ack_i = 1'b0;
   logic [7:0] rx_byte_i = 8'h00;
   logic       req_o, keep_sel_o, busy_o, done_o;
   logic [7:0] tx_byte_o;
   logic [2:0] kind_o;
   logic [4:0] addr_bits_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   savemem_probe dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_o(req_o),
      .tx_byte_o(tx_byte_o), .keep_sel_o(keep_sel_o), .ack_i(ack_i),
      .rx_byte_i(rx_byte_i), .busy_o(busy_o), .done_o(done_o),
      .kind_o(kind_o), .addr_bits_o(addr_bits_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void expect_of(input logic [7:0] st, input logic [23:0] id,
                                     output int kind, output int bits);
      if (id == 24'hFFFFFF) begin
         if (st == 8'hFF)      begin kind = 0; bits = 0;  end
         else if (st == 8'hF0) begin kind = 1; bits = 9;  end
         else if (st == 8'h00) begin kind = 2; bits = 16; end
         else                  begin kind = 4; bits = 0;  end
      end else if (st == 8'h00) begin kind = 3; bits = 24; end
      else                      begin kind = 4; bits = 0;  end
   endfunction

   task automatic run_probe(input logic [7:0] st, input logic [23:0] id,
                            input int lat, input bit stray);
      logic [7:0] exp_tx;
      bit         exp_keep;
      int         ek, eb;
      expect_of(st, id, ek, eb);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int b = 0; b < 6; b++) begin
         int guard = 0;
         while (!req_o && guard < 20) begin @(negedge clk); guard++; end
         exp_tx   = (b == 0) ? 8'h05 : (b == 2) ? 8'h9F : 8'hFF;
         exp_keep = !(b == 1 || b == 5);
         if (b < 2) begin
            chk(tx_byte_o == exp_tx, "R2 byte", tx_byte_o, exp_tx);
            chk(keep_sel_o == exp_keep, "R2 keep", keep_sel_o, exp_keep);
         end else begin
            chk(tx_byte_o == exp_tx, "R3 byte", tx_byte_o, exp_tx);
            chk(keep_sel_o == exp_keep, "R3 keep", keep_sel_o, exp_keep);
         end
         for (int w = 0; w < lat; w++) begin
            if (stray && b == 3 && w == 0) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(req_o && tx_byte_o == exp_tx, "R11 hold", tx_byte_o, exp_tx);
            chk(!done_o, "R4 early", done_o, 0);
         end
         if (stray && b == 3 && lat == 0) start_i = 1'b1;
         ack_i = 1'b1;
         rx_byte_i = (b == 1) ? st : (b >= 3) ? id[(b-3)*8 +: 8] : 8'hA5;
         @(negedge clk);
         ack_i = 1'b0;
         start_i = 1'b0;
         if (b < 5) chk(!done_o, "R4 early", done_o, 0);
      end
      chk(done_o == 1'b1, "R4 strobe", done_o, 1);
      case (ek)
         0: chk(kind_o == 3'd0 && addr_bits_o == 5'd0, "R5 none", {kind_o, addr_bits_o}, {3'(ek), 5'(eb)});
         1: chk(kind_o == 3'd1 && addr_bits_o == 5'd9, "R6 ee9", {kind_o, addr_bits_o}, {3'(ek), 5'(eb)});
         2: chk(kind_o == 3'd2 && addr_bits_o == 5'd16, "R7 ee16", {kind_o, addr_bits_o}, {3'(ek), 5'(eb)});
         3: chk(kind_o == 3'd3 && addr_bits_o == 5'd24, "R8 flash", {kind_o, addr_bits_o}, {3'(ek), 5'(eb)});
         default: chk(kind_o == 3'd4 && addr_bits_o == 5'd0, "R9 unknown", {kind_o, addr_bits_o}, {3'(ek), 5'(eb)});
      endcase
      chk(!req_o && !busy_o, "R10 idle after done", {req_o, busy_o}, 0);
      @(negedge clk);
      chk(!done_o, "R4 one cycle", done_o, 0);
      @(negedge clk);
      chk(!req_o && !busy_o, "R10 no restart", {req_o, busy_o}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0]  sts [5] = '{8'h00, 8'hF0, 8'hFF, 8'h0F, 8'h80};
      logic [23:0] ids [5] = '{24'hFFFFFF, 24'h00FFFF, 24'hFFFF20, 24'hFF12FF, 24'h000000};
      repeat (3) @(negedge clk);
      chk(!req_o && !busy_o && !done_o, "R1 reset", {req_o, busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!req_o && !busy_o && !done_o, "R1 idle", {req_o, busy_o, done_o}, 0);
      for (int s = 0; s < 5; s++) begin
         for (int i = 0; i < 5; i++) begin
            int c = s * 5 + i;
            run_probe(sts[s], ids[i], c % 3, (c == 7) || (c == 19));
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule